// File: doc/BRIEF.md
# DSP Data Address Generator

This block computes data-memory addresses for a signal-processing datapath. It keeps a small file of address registers. On each access one register is named, its present value is sent out as the address, and the register is rewritten on the same clock edge with a post-modified value. Each access picks one of four update rules: hold, linear stepping by a scaled signed offset, stepping that wraps inside a circular buffer, or reverse-carry stepping that walks a radix-2 FFT index field in bit-reversed order.

Each register has its own circular-buffer base, buffer length and FFT field size. All of these, and the address itself, are loaded through a separate configuration port. A delay line can therefore advance one sample per access without moving data, and FFT operands come out in the order a butterfly pass needs. The whole update is combinational between the register and its write-back, so every access takes one cycle. The block does not decode instructions and does not contain the memory.

Top module: `agu_top`

## Requirements
- R1: After synchronous active-low reset every address, base, length and FFT-size register is zero, so `addr_out` reads 0 for every select.
- R2: `addr_out` is the selected register's value before modification. When `acc_req` is high, the register takes the value shown on `next_addr` at the next rising edge.
- R3: Mode code 0 and the undefined codes 4 to 7 leave the register unchanged (`next_addr` equals `addr_out`).
- R4: Mode code 1 (linear) adds the sign-extended offset scaled by the element size: `acc_esize` 0 multiplies by 1 (bytes), 1 by 2 (halfwords), 2 by 4 (words), and 3 by 1. The result wraps modulo 2^ADDR_W.
- R5: Mode code 2 (circular) with a nonzero length L and base B: a scaled step that passes B+L-1 wraps around to continue from B.
- R6: Mode code 2 with a step that falls below B continues from B+L-1. This is correct for any step magnitude below L when the address starts inside the buffer. A length of 0 leaves the register unchanged.
- R7: Mode code 3 (bit-reversed) with field size k (1 to ADDR_W) adds 2^(k-1) with the carry running from bit k-1 down toward bit 0, dropping the final carry. Bits k and above are unchanged. A k of 0 or above ADDR_W leaves the register unchanged.
- R8: A configuration write (`cfg_we`) stores `cfg_data` into the register selected by `cfg_sel`. The field code is 0 for address, 1 for base, 2 for length, and 3 for FFT field size (low bits). The value is visible from the next cycle.
- R9: If a configuration write to the address field names the same register as an access in the same cycle, the configured value wins.
- R10: Registers other than the one accessed or configured keep their values, and with neither `acc_req` nor `cfg_we` no address register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | Access strobe; writes back the post-modified value |
| acc_sel | input | SEL_W | Address register used by the access |
| acc_mode | input | 3 | Update rule: 0 hold, 1 linear, 2 circular, 3 bit-reversed, others hold |
| acc_ofs | input | OFS_W | Signed step in elements |
| acc_esize | input | 2 | Element size: 0 byte, 1 halfword, 2 word, 3 byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Register written by the configuration port |
| cfg_field | input | 2 | 0 address, 1 base, 2 length, 3 FFT field size |
| cfg_data | input | ADDR_W | Configuration value |
| addr_out | output | ADDR_W | Selected register before modification |
| next_addr | output | ADDR_W | Post-modified value for the selected register |

## Verification
The linear rule is driven with positive and negative offsets at every element size. This separates a wrong scale shift from a missing sign extension. The circular rule is run forward through the top of a five-entry buffer, backward through its base, and with strides of three and four, so an off-by-one bound or a wrap that ignores the overshoot gives a different address. The bit-reversed rule walks a full eight-point cycle above a nonzero upper field, and also at the widest field size, so carry direction, carry drop and preservation of the upper bits are each seen on their own. Hold codes, idle cycles, a same-cycle configuration collision and reads of neighbouring registers show that nothing else is written.

// File: rtl/agu_pkg.sv
// Shared codes for the data address generator.
// Assumes mode is 3 bits wide and the configuration field code is 2 bits wide.
package agu_pkg;
    typedef enum logic [2:0] {
        MODE_HOLD = 3'd0,
        MODE_LIN  = 3'd1,
        MODE_CIRC = 3'd2,
        MODE_REV  = 3'd3
    } agu_mode_e;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_BASE = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_LOGN = 2'd3
    } agu_field_e;
endpackage

// File: rtl/agu_regs.sv
// Register file of the address generator: one address, base, length and
// FFT field size per entry. Assumes that when an access and a configuration
// write hit the same address register, the configuration write wins.
module agu_regs
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 4,
    parameter int SEL_W  = 2,
    parameter int LOGW   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_en,
    input  logic [SEL_W-1:0]       upd_sel,
    input  logic [ADDR_W-1:0]      upd_val,
    input  logic                   cfg_we,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  logic [1:0]             cfg_field,
    input  logic [ADDR_W-1:0]      cfg_data,
    output logic [NREG*ADDR_W-1:0] ar_flat,
    output logic [NREG*ADDR_W-1:0] base_flat,
    output logic [NREG*ADDR_W-1:0] len_flat,
    output logic [NREG*LOGW-1:0]   logn_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_entry
        logic [ADDR_W-1:0] ar_r, base_r, len_r;
        logic [LOGW-1:0]   logn_r;
        logic              hit_upd, hit_cfg;

        assign hit_upd = upd_en && (upd_sel == SEL_W'(i));
        assign hit_cfg = cfg_we && (cfg_sel == SEL_W'(i));

        // Update one entry: access write-back first, configuration overrides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ar_r   <= '0;
                base_r <= '0;
                len_r  <= '0;
                logn_r <= '0;
            end else begin
                if (hit_upd) ar_r <= upd_val;
                if (hit_cfg) begin
                    case (cfg_field)
                        FLD_ADDR: ar_r   <= cfg_data;
                        FLD_BASE: base_r <= cfg_data;
                        FLD_LEN:  len_r  <= cfg_data;
                        default:  logn_r <= cfg_data[LOGW-1:0];
                    endcase
                end
            end
        end

        assign ar_flat[i*ADDR_W +: ADDR_W]   = ar_r;
        assign base_flat[i*ADDR_W +: ADDR_W] = base_r;
        assign len_flat[i*ADDR_W +: ADDR_W]  = len_r;
        assign logn_flat[i*LOGW +: LOGW]     = logn_r;
    end
endmodule

// File: rtl/agu_circ.sv
// Circular-buffer step: moves an address by a signed step and folds the
// result back into [base, base+len-1]. Assumes the address is already in
// the buffer and |step| < len; len of 0 returns the address unchanged.
module agu_circ #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] nxt
);
    localparam int WL = ADDR_W + 2;

    logic signed [WL-1:0] pos, moved, lenx, folded;

    // Offset inside the buffer, stepped, then folded once in either direction.
    always_comb begin
        pos   = $signed({2'b00, cur}) - $signed({2'b00, base});
        moved = pos + $signed({{2{step[ADDR_W-1]}}, step});
        lenx  = $signed({2'b00, len});
        if (moved >= lenx)
            folded = moved - lenx;
        else if (moved < 0)
            folded = moved + lenx;
        else
            folded = moved;
        nxt = (len == '0) ? cur : base + folded[ADDR_W-1:0];
    end
endmodule

// File: rtl/agu_revcarry.sv
// Reverse-carry increment for FFT index order: adds 2^(logn-1) to the low
// logn bits with the carry moving toward bit 0. Bits at logn and above are
// kept. Assumes logn of 0 or above ADDR_W means no change.
module agu_revcarry #(
    parameter int ADDR_W = 32,
    parameter int LOGW   = 6
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [LOGW-1:0]   logn,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] mirrored, inc, summed;
    logic              in_range;

    assign in_range = (logn != '0) && (int'(logn) <= ADDR_W);

    // Mirror the word, add one at the mirrored top of the field, mirror back.
    always_comb begin
        for (int b = 0; b < ADDR_W; b++) mirrored[b] = cur[ADDR_W-1-b];
        inc = '0;
        if (in_range) inc[ADDR_W - int'(logn)] = 1'b1;
        summed = mirrored + inc;
        for (int b = 0; b < ADDR_W; b++) nxt[b] = summed[ADDR_W-1-b];
    end
endmodule

// File: rtl/agu_top.sv
// Data address generator top. Presents the selected register as the address
// and its post-modified value, and writes that value back on the access edge.
// Assumes OFS_W + 2 < ADDR_W and that acc_sel below NREG names a register.
module agu_top
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 4,
    parameter int OFS_W  = 16,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int LOGW  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [2:0]        acc_mode,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [1:0]        acc_esize,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] next_addr
);
    logic [NREG*ADDR_W-1:0] ar_flat, base_flat, len_flat;
    logic [NREG*LOGW-1:0]   logn_flat;
    logic [ADDR_W-1:0]      sel_addr, sel_base, sel_len;
    logic [LOGW-1:0]        sel_logn;
    logic [ADDR_W-1:0]      ofs_ext, step, lin_val, circ_val, rev_val;

    agu_regs #(.ADDR_W(ADDR_W), .NREG(NREG), .SEL_W(SEL_W), .LOGW(LOGW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (acc_req),
        .upd_sel   (acc_sel),
        .upd_val   (next_addr),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_field (cfg_field),
        .cfg_data  (cfg_data),
        .ar_flat   (ar_flat),
        .base_flat (base_flat),
        .len_flat  (len_flat),
        .logn_flat (logn_flat)
    );

    // Pick the selected entry's address and its buffer settings.
    always_comb begin
        sel_addr = '0;
        sel_base = '0;
        sel_len  = '0;
        sel_logn = '0;
        for (int i = 0; i < NREG; i++) begin
            if (acc_sel == SEL_W'(i)) begin
                sel_addr = ar_flat[i*ADDR_W +: ADDR_W];
                sel_base = base_flat[i*ADDR_W +: ADDR_W];
                sel_len  = len_flat[i*ADDR_W +: ADDR_W];
                sel_logn = logn_flat[i*LOGW +: LOGW];
            end
        end
    end

    // Sign-extend the element offset and scale it to a byte step.
    always_comb begin
        ofs_ext = {{(ADDR_W-OFS_W){acc_ofs[OFS_W-1]}}, acc_ofs};
        case (acc_esize)
            2'd1:    step = ofs_ext << 1;
            2'd2:    step = ofs_ext << 2;
            default: step = ofs_ext;
        endcase
    end

    assign lin_val = sel_addr + step;

    agu_circ #(.ADDR_W(ADDR_W)) u_circ (
        .cur  (sel_addr),
        .step (step),
        .base (sel_base),
        .len  (sel_len),
        .nxt  (circ_val)
    );

    agu_revcarry #(.ADDR_W(ADDR_W), .LOGW(LOGW)) u_rev (
        .cur  (sel_addr),
        .logn (sel_logn),
        .nxt  (rev_val)
    );

    // Choose the post-modified value from the access mode.
    always_comb begin
        case (acc_mode)
            MODE_LIN:  next_addr = lin_val;
            MODE_CIRC: next_addr = circ_val;
            MODE_REV:  next_addr = rev_val;
            default:   next_addr = sel_addr;
        endcase
    end

    assign addr_out = sel_addr;
endmodule

// File: rtl/agu_checker.sv
// Property checker for agu_top, bound to every instance. Observes ports,
// the flattened address registers and the selected buffer settings.
module agu_checker #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 4,
    parameter int SEL_W  = 2,
    parameter int LOGW   = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_req,
    input logic [SEL_W-1:0]       acc_sel,
    input logic [2:0]             acc_mode,
    input logic                   cfg_we,
    input logic [SEL_W-1:0]       cfg_sel,
    input logic [1:0]             cfg_field,
    input logic [ADDR_W-1:0]      cfg_data,
    input logic [ADDR_W-1:0]      addr_out,
    input logic [ADDR_W-1:0]      next_addr,
    input logic [ADDR_W-1:0]      sel_base,
    input logic [ADDR_W-1:0]      sel_len,
    input logic [LOGW-1:0]        sel_logn,
    input logic [NREG*ADDR_W-1:0] ar_flat
);
    logic              upd_pend, cfg_pend;
    logic [SEL_W-1:0]  upd_sel_q, cfg_sel_q;
    logic [ADDR_W-1:0] upd_val_q, cfg_val_q;
    logic              cfg_addr_hit;

    assign cfg_addr_hit = cfg_we && (cfg_field == 2'd0);

    // Remember the value each write should leave in its register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pend  <= 1'b0;
            cfg_pend  <= 1'b0;
            upd_sel_q <= '0;
            cfg_sel_q <= '0;
            upd_val_q <= '0;
            cfg_val_q <= '0;
        end else begin
            upd_pend  <= acc_req && !(cfg_addr_hit && cfg_sel == acc_sel);
            upd_sel_q <= acc_sel;
            upd_val_q <= next_addr;
            cfg_pend  <= cfg_addr_hit;
            cfg_sel_q <= cfg_sel;
            cfg_val_q <= cfg_data;
        end
    end

    assert_writeback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && int'(upd_sel_q) < NREG && !(cfg_pend && cfg_sel_q == upd_sel_q))
        |-> ar_flat[int'(upd_sel_q)*ADDR_W +: ADDR_W] == upd_val_q);

    assert_cfg_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pend && int'(cfg_sel_q) < NREG)
        |-> ar_flat[int'(cfg_sel_q)*ADDR_W +: ADDR_W] == cfg_val_q);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && (acc_mode == 3'd0 || acc_mode > 3'd3)) |-> next_addr == addr_out);

    assert_circ_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_mode == 3'd2 && sel_len != '0 && addr_out >= sel_base
         && (addr_out - sel_base) < sel_len)
        |-> (next_addr >= sel_base && (next_addr - sel_base) < sel_len));

    assert_rev_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_mode == 3'd3 && sel_logn != '0 && int'(sel_logn) <= ADDR_W)
        |-> (next_addr >> sel_logn) == (addr_out >> sel_logn));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_req && !cfg_we) |=> $stable(ar_flat));
endmodule

bind agu_top agu_checker #(.ADDR_W(ADDR_W), .NREG(NREG), .SEL_W(SEL_W), .LOGW(LOGW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_sel   (acc_sel),
    .acc_mode  (acc_mode),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_field (cfg_field),
    .cfg_data  (cfg_data),
    .addr_out  (addr_out),
    .next_addr (next_addr),
    .sel_base  (sel_base),
    .sel_len   (sel_len),
    .sel_logn  (sel_logn),
    .ar_flat   (ar_flat)
);

// File: tb/tb_agu_top.sv
// Bench for agu_top: behavioural reference model updated on every clock,
// outputs compared half a cycle after each edge.
module tb_agu_top;
    localparam int AW = 32;
    localparam int NR = 4;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0;
    logic [1:0]    acc_sel = '0;
    logic [2:0]    acc_mode = '0;
    logic [OW-1:0] acc_ofs = '0;
    logic [1:0]    acc_esize = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [1:0]    cfg_field = '0;
    logic [AW-1:0] cfg_data = '0;
    logic [AW-1:0] addr_out, next_addr;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ar [NR];
    logic [31:0] m_base [NR];
    logic [31:0] m_len [NR];
    int          m_logn [NR];

    agu_top #(.ADDR_W(AW), .NREG(NR), .OFS_W(OW)) dut (
        .clk, .rst_n, .acc_req, .acc_sel, .acc_mode, .acc_ofs, .acc_esize,
        .cfg_we, .cfg_sel, .cfg_field, .cfg_data, .addr_out, .next_addr
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] model_next(int sel, int mode, int ofs, int esz);
        logic [31:0] cur = m_ar[sel];
        longint step = longint'(ofs) * ((esz == 1) ? 2 : (esz == 2) ? 4 : 1);
        longint pos;
        logic [31:0] r;
        logic [31:0] res;
        int k;
        case (mode)
            1: return cur + step[31:0];
            2: begin
                if (m_len[sel] == 0) return cur;
                pos = longint'({32'h0, cur}) - longint'({32'h0, m_base[sel]}) + step;
                if (pos >= longint'({32'h0, m_len[sel]})) pos -= longint'({32'h0, m_len[sel]});
                else if (pos < 0) pos += longint'({32'h0, m_len[sel]});
                return m_base[sel] + pos[31:0];
            end
            3: begin
                k = m_logn[sel];
                if (k == 0 || k > 32) return cur;
                r = 0;
                for (int i = 0; i < k; i++) r[i] = cur[k-1-i];
                r = r + 1;
                res = cur;
                for (int i = 0; i < k; i++) res[i] = r[k-1-i];
                return res;
            end
            default: return cur;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare against model, then advance the model.
    task automatic cyc(string tag, bit req, int sel, int mode, int ofs, int esz,
                       bit cwe, int csel, int cfld, logic [31:0] cdat);
        logic [31:0] exp_n;
        @(negedge clk);
        acc_req = req; acc_sel = 2'(sel); acc_mode = 3'(mode);
        acc_ofs = OW'(ofs); acc_esize = 2'(esz);
        cfg_we = cwe; cfg_sel = 2'(csel); cfg_field = 2'(cfld); cfg_data = cdat;
        #2;
        exp_n = model_next(sel, mode, ofs, esz);
        check(tag, "addr_out", addr_out, m_ar[sel]);
        check(tag, "next_addr", next_addr, exp_n);
        @(posedge clk);
        if (req) m_ar[sel] = exp_n;
        if (cwe) begin
            case (cfld)
                0: m_ar[csel] = cdat;
                1: m_base[csel] = cdat;
                2: m_len[csel] = cdat;
                default: m_logn[csel] = int'(cdat[5:0]);
            endcase
        end
    endtask

    task automatic acc(string tag, int sel, int mode, int ofs, int esz);
        cyc(tag, 1'b1, sel, mode, ofs, esz, 1'b0, 0, 0, 32'h0);
    endtask

    task automatic cfg(string tag, int csel, int cfld, logic [31:0] cdat);
        cyc(tag, 1'b0, csel, 0, 0, 0, 1'b1, csel, cfld, cdat);
    endtask

    task automatic peek(string tag, int sel);
        cyc(tag, 1'b0, sel, 0, 0, 0, 1'b0, 0, 0, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_ar[i] = 0; m_base[i] = 0; m_len[i] = 0; m_logn[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: everything zero after reset
        for (int s = 0; s < NR; s++) peek("R1", s);

        // R8: load addresses and buffer settings, then read back
        cfg("R8", 0, 0, 32'h0000_0100);
        cfg("R8", 0, 1, 32'h0000_0100);
        cfg("R8", 0, 2, 32'd5);
        cfg("R8", 1, 0, 32'h0000_1000);
        cfg("R8", 2, 0, 32'h000A_BC00);
        cfg("R8", 2, 3, 32'd3);
        cfg("R8", 3, 0, 32'h0000_0000);
        cfg("R8", 3, 3, 32'd32);
        for (int s = 0; s < NR; s++) peek("R8", s);

        // R4 and R2: linear steps at every element size, both signs
        acc("R4", 1, 1, 1, 0);
        acc("R4", 1, 1, 1, 1);
        acc("R4", 1, 1, 1, 2);
        acc("R4", 1, 1, -3, 2);
        acc("R4", 1, 1, 2, 3);
        acc("R4", 1, 1, -32768, 2);
        peek("R2", 1);

        // R5: circular forward through the top, then stride 3
        for (int n = 0; n < 6; n++) acc("R5", 0, 2, 1, 0);
        acc("R5", 0, 2, 3, 0);
        acc("R5", 0, 2, 3, 0);
        peek("R5", 0);

        // R6: circular backward through the base, stride 4, and zero length
        for (int n = 0; n < 4; n++) acc("R6", 0, 2, -1, 0);
        acc("R6", 0, 2, -4, 0);
        peek("R6", 0);
        acc("R6", 1, 2, 1, 0);

        // R7: eight-point bit-reversed walk above a nonzero upper field
        for (int n = 0; n < 9; n++) acc("R7", 2, 3, 0, 0);
        acc("R7", 3, 3, 0, 0);
        acc("R7", 3, 3, 0, 0);
        cfg("R7", 3, 3, 32'd0);
        acc("R7", 3, 3, 0, 0);
        cfg("R7", 3, 3, 32'd40);
        acc("R7", 3, 3, 0, 0);

        // R3: hold code and undefined codes
        acc("R3", 1, 0, 7, 2);
        acc("R3", 1, 5, 7, 2);
        acc("R3", 1, 7, 7, 2);
        peek("R3", 1);

        // R10: idle cycle and access elsewhere leave register 0 alone
        peek("R10", 0);
        acc("R10", 1, 1, 4, 0);
        peek("R10", 0);
        peek("R10", 2);

        // R9: configuration write collides with an access on the same register
        cyc("R9", 1'b1, 0, 2, 1, 0, 1'b1, 0, 0, 32'h0000_0103);
        peek("R9", 0);
        acc("R9", 0, 2, 2, 0);
        peek("R9", 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule